// File: doc/BRIEF.md
# Half-Bridge Protection and Latch Controller

This block sits between a serial command receiver and the gate drivers of three half-bridges. Each time a complete command frame is accepted, the receiver presents the 16-bit word together with a one-cycle load strobe. The block keeps the requested high-side and low-side enables from that word. It then masks them with every protection condition before they reach the six gate-enable outputs.

The protection conditions are as follows:
- Shoot-through attempts.
- Per-driver overcurrent, filtered by a delay counter.
- Supply undervoltage and overvoltage.
- Per-channel thermal warning and thermal shutdown.

Faults either latch a driver off or set a sticky status flag. Both are released only by a command that carries the status-reset bit. The overcurrent delay has a long setting and a short setting, and the command picks one of them. A delay that has already started keeps the setting it started with.

Top module: `hb_guard`

## Requirements
- R1: After reset all six gate enables are low and all four status flags are low.
- R2: On a load strobe, command bit 2b+1 requests the low-side and bit 2b+2 requests the high-side driver of bridge b (b = 0..2). With no fault present, the gate enables equal the requested state from the cycle after the load edge.
- R3: A command requesting both drivers of one bridge forces both of them off and sets the shoot-through flag. The bridge stays off through later commands until a command with the status-reset bit (bit 0) is loaded. A status-reset command without a conflict restores the bridge.
- R4: A driver that is on while its overcurrent input is high for a full delay turns off and sets the overcurrent flag. The driver turns off at the delay-th rising edge. Command bit 13 = 0 selects LONG_DLY cycles and bit 13 = 1 selects SHORT_DLY cycles.
- R5: The delay setting is captured when counting starts. A bit 13 value loaded while the count runs does not change that count.
- R6: An overcurrent-latched driver stays off under commands without the status-reset bit. A command with the status-reset bit clears the latch and the overcurrent flag.
- R7: The overvoltage input sets the supply-fail flag, whether or not lockout is enabled. The flag stays set until a status-reset command is loaded.
- R8: With command bit 15 = 1, all gate enables are low while the overvoltage input is high. The programmed states return by themselves once it falls. With bit 15 = 0, overvoltage does not affect the gates.
- R9: While the undervoltage input is high, all gate enables are low.
- R10: Any thermal-warning input sets the thermal-warning flag. The drivers keep running. The flag stays set after the input falls, until a status-reset command is loaded.
- R11: Any thermal-shutdown input latches all drivers off. A status-reset command loaded while the input is still high does not release them. A status-reset command loaded after the input has fallen does release them.
- R12: An overcurrent pulse shorter than the delay does not latch the driver. The count restarts from zero when the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_word | input | 16 | Latched command word from the serial receiver |
| cmd_load | input | 1 | One-cycle strobe marking a valid frame |
| oc_hi | input | 3 | Overcurrent comparator, high-side driver per bridge |
| oc_lo | input | 3 | Overcurrent comparator, low-side driver per bridge |
| tw_flag | input | 3 | Thermal warning per channel |
| tsd_flag | input | 3 | Thermal shutdown per channel |
| uv_flag | input | 1 | Supply undervoltage |
| ov_flag | input | 1 | Supply overvoltage |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| st_shoot | output | 1 | Shoot-through attempt flag |
| st_ocur | output | 1 | Overcurrent latch flag |
| st_supply | output | 1 | Supply-fail flag |
| st_twarn | output | 1 | Thermal-warning flag |

## Verification
The assertions assume that the comparator and supply inputs are synchronous to the clock and change only between edges. They also assume that cmd_load is a single-cycle strobe with cmd_word stable while it is high. The bench drives every input on the falling edge and holds each load strobe for exactly one cycle. It raises and lowers fault inputs only at those points. Each overcurrent window is therefore an exact count of rising edges.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
   localparam int CMD_W    = 16;
   localparam int SRR_POS  = 0;   // status reset request
   localparam int DLY_POS  = 13;  // overcurrent delay select
   localparam int LOCK_POS = 15;  // overvoltage lockout enable

   function automatic int lo_pos(input int b);
      return 2 * b + 1;
   endfunction

   function automatic int hi_pos(input int b);
      return 2 * b + 2;
   endfunction
endpackage

// File: rtl/hbg_oc_timer.sv
`timescale 1ns/1ps
module hbg_oc_timer #(
   parameter int LONG_DLY  = 200,
   parameter int SHORT_DLY = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_on,
   input  logic oc_in,
   input  logic short_sel,
   input  logic clr,
   output logic latched
);
   localparam int MAXD = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
   localparam int CW   = $clog2(MAXD + 1);
   localparam logic [CW-1:0] LONG_M1  = CW'(LONG_DLY - 1);
   localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_DLY - 1);

   logic [CW-1:0] cnt;
   logic          sel_q;
   logic          active;
   logic          use_short;
   logic [CW-1:0] lim_m1;
   logic          expire;

   assign active    = gate_on & oc_in;
   assign use_short = (cnt == '0) ? short_sel : sel_q;
   assign lim_m1    = use_short ? SHORT_M1 : LONG_M1;
   assign expire    = active & (cnt == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         sel_q   <= 1'b0;
         latched <= 1'b0;
      end else begin
         if (active) begin
            if (cnt == '0) sel_q <= short_sel;
            cnt <= expire ? '0 : cnt + 1'b1;
         end else begin
            cnt <= '0;
         end
         if (expire)   latched <= 1'b1;
         else if (clr) latched <= 1'b0;
      end
   end

   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(MAXD));
   a_r4_latched_off: assert property (@(posedge clk) disable iff (!rst_n)
      latched |-> !gate_on);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !clr) |=> latched);
   a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0));
endmodule

// File: rtl/hbg_sticky.sv
`timescale 1ns/1ps
module hbg_sticky #(
   parameter bit CLR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   generate
      if (CLR_WINS) begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   flag <= 1'b0;
            else if (clr) flag <= 1'b0;
            else if (set) flag <= 1'b1;
         end
         a_r7_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
            (set && !clr) |=> flag);
      end else begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   flag <= 1'b0;
            else if (set) flag <= 1'b1;
            else if (clr) flag <= 1'b0;
         end
         a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
            set |=> flag);
      end
   endgenerate

   a_r7_r10_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/hb_guard.sv
`timescale 1ns/1ps
module hb_guard #(
   parameter int N_BRIDGE  = 3,
   parameter int LONG_DLY  = 200,
   parameter int SHORT_DLY = 25
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [hbg_pkg::CMD_W-1:0]  cmd_word,
   input  logic                       cmd_load,
   input  logic [N_BRIDGE-1:0]        oc_hi,
   input  logic [N_BRIDGE-1:0]        oc_lo,
   input  logic [N_BRIDGE-1:0]        tw_flag,
   input  logic [N_BRIDGE-1:0]        tsd_flag,
   input  logic                       uv_flag,
   input  logic                       ov_flag,
   output logic [N_BRIDGE-1:0]        gate_hi,
   output logic [N_BRIDGE-1:0]        gate_lo,
   output logic                       st_shoot,
   output logic                       st_ocur,
   output logic                       st_supply,
   output logic                       st_twarn
);
   import hbg_pkg::*;

   generate
      if (N_BRIDGE < 1 || hi_pos(N_BRIDGE - 1) >= 12) begin : g_bad_nb
         $error("N_BRIDGE does not fit the command word");
      end
      if (LONG_DLY < 2 || SHORT_DLY < 2) begin : g_bad_dly
         $error("delays must be at least two cycles");
      end
   endgenerate

   logic [N_BRIDGE-1:0] req_hi, req_lo, sta_blk, both, oc_lat_hi, oc_lat_lo;
   logic                dly_short, lock_en, srr, tsd_lat, global_off;

   assign srr = cmd_load & cmd_word[SRR_POS];

   for (genvar b = 0; b < N_BRIDGE; b++) begin : g_dec
      assign both[b] = cmd_word[lo_pos(b)] & cmd_word[hi_pos(b)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_hi    <= '0;
         req_lo    <= '0;
         sta_blk   <= '0;
         dly_short <= 1'b0;
         lock_en   <= 1'b0;
      end else if (cmd_load) begin
         for (int b = 0; b < N_BRIDGE; b++) begin
            req_lo[b] <= cmd_word[lo_pos(b)];
            req_hi[b] <= cmd_word[hi_pos(b)];
         end
         sta_blk   <= (srr ? '0 : sta_blk) | both;
         dly_short <= cmd_word[DLY_POS];
         lock_en   <= cmd_word[LOCK_POS];
      end
   end

   assign global_off = uv_flag | (ov_flag & lock_en) | tsd_lat | (|tsd_flag);

   for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
      assign gate_hi[b] = req_hi[b] & ~sta_blk[b] & ~oc_lat_hi[b] & ~global_off;
      assign gate_lo[b] = req_lo[b] & ~sta_blk[b] & ~oc_lat_lo[b] & ~global_off;

      hbg_oc_timer #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) u_oc_hi (
         .clk(clk), .rst_n(rst_n), .gate_on(gate_hi[b]), .oc_in(oc_hi[b]),
         .short_sel(dly_short), .clr(srr), .latched(oc_lat_hi[b]));
      hbg_oc_timer #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) u_oc_lo (
         .clk(clk), .rst_n(rst_n), .gate_on(gate_lo[b]), .oc_in(oc_lo[b]),
         .short_sel(dly_short), .clr(srr), .latched(oc_lat_lo[b]));
   end

   hbg_sticky #(.CLR_WINS(1'b1)) u_supply (
      .clk(clk), .rst_n(rst_n), .set(ov_flag), .clr(srr), .flag(st_supply));
   hbg_sticky #(.CLR_WINS(1'b1)) u_twarn (
      .clk(clk), .rst_n(rst_n), .set(|tw_flag), .clr(srr), .flag(st_twarn));
   hbg_sticky #(.CLR_WINS(1'b0)) u_tsd (
      .clk(clk), .rst_n(rst_n), .set(|tsd_flag), .clr(srr), .flag(tsd_lat));

   assign st_shoot = |sta_blk;
   assign st_ocur  = |{oc_lat_hi, oc_lat_lo};

   a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi & gate_lo) == '0);
   a_r3_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_shoot && !srr) |=> st_shoot);
   a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_flag && lock_en) |-> ((gate_hi | gate_lo) == '0));
   a_r9_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |-> ((gate_hi | gate_lo) == '0));
   a_r11_tsd_off: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_lat |-> ((gate_hi | gate_lo) == '0));
endmodule

// File: tb/hb_guard_tb.sv
`timescale 1ns/1ps
module hb_guard_tb;
   localparam int LONG  = 200;
   localparam int SHORT = 25;

   typedef struct packed {
      logic [15:0] cmd;
      logic [2:0]  hi;
      logic [2:0]  lo;
      logic        sta;
   } vec_t;

   // R2 / R3 mapping vectors, each with the status-reset bit set
   localparam vec_t VEC [7] = '{
      '{16'h0001, 3'b000, 3'b000, 1'b0},
      '{16'h0003, 3'b000, 3'b001, 1'b0},
      '{16'h000D, 3'b001, 3'b010, 1'b0},
      '{16'h0051, 3'b110, 3'b000, 1'b0},
      '{16'h001B, 3'b000, 3'b001, 1'b1},
      '{16'h002B, 3'b000, 3'b111, 1'b0},
      '{16'h0055, 3'b111, 3'b000, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        cmd_load = 1'b0;
   logic [2:0]  oc_hi = '0, oc_lo = '0, tw_flag = '0, tsd_flag = '0;
   logic        uv_flag = 1'b0, ov_flag = 1'b0;
   logic [2:0]  gate_hi, gate_lo;
   logic        st_shoot, st_ocur, st_supply, st_twarn;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   hb_guard #(.N_BRIDGE(3), .LONG_DLY(LONG), .SHORT_DLY(SHORT)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_load(cmd_load),
      .oc_hi(oc_hi), .oc_lo(oc_lo), .tw_flag(tw_flag), .tsd_flag(tsd_flag),
      .uv_flag(uv_flag), .ov_flag(ov_flag), .gate_hi(gate_hi), .gate_lo(gate_lo),
      .st_shoot(st_shoot), .st_ocur(st_ocur), .st_supply(st_supply),
      .st_twarn(st_twarn));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w);
      cmd_word = w;
      cmd_load = 1'b1;
      @(negedge clk);
      cmd_load = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 gates", {gate_hi, gate_lo}, 0);
      chk("R1 flags", {st_shoot, st_ocur, st_supply, st_twarn}, 0);

      for (int i = 0; i < 7; i++) begin
         send(VEC[i].cmd);
         chk("R2 high gates", gate_hi, VEC[i].hi);
         chk("R2 low gates", gate_lo, VEC[i].lo);
         chk("R3 shoot flag", st_shoot, VEC[i].sta);
      end

      // R3: conflict without reset, then blocked, then released
      send(16'h0006);
      chk("R3 bridge off", {gate_hi[0], gate_lo[0]}, 0);
      chk("R3 flag set", st_shoot, 1);
      send(16'h0004);
      chk("R3 still blocked", gate_hi[0], 0);
      send(16'h0005);
      chk("R3 released", {gate_hi[0], st_shoot}, 2'b10);

      // R4 long delay, then R6 latch release
      oc_hi[0] = 1'b1;
      repeat (LONG - 1) @(posedge clk);
      @(negedge clk);
      chk("R4 on before long delay", gate_hi[0], 1);
      @(posedge clk);
      @(negedge clk);
      chk("R4 off at long delay", {gate_hi[0], st_ocur}, 2'b01);
      oc_hi[0] = 1'b0;
      send(16'h0004);
      chk("R6 no release without reset", {gate_hi[0], st_ocur}, 2'b01);
      send(16'h0005);
      chk("R6 release with reset", {gate_hi[0], st_ocur}, 2'b10);

      // R4 short delay
      send(16'h2005);
      oc_hi[0] = 1'b1;
      repeat (SHORT - 1) @(posedge clk);
      @(negedge clk);
      chk("R4 on before short delay", gate_hi[0], 1);
      @(posedge clk);
      @(negedge clk);
      chk("R4 off at short delay", {gate_hi[0], st_ocur}, 2'b01);
      oc_hi[0] = 1'b0;
      send(16'h0005);

      // R5: long count started, short select arrives mid-count
      oc_hi[0] = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      send(16'h2004);
      repeat (SHORT - 6) @(posedge clk);
      @(negedge clk);
      chk("R5 frozen delay past short", gate_hi[0], 1);
      repeat (LONG - SHORT - 1) @(posedge clk);
      @(negedge clk);
      chk("R5 on before long", gate_hi[0], 1);
      @(posedge clk);
      @(negedge clk);
      chk("R5 off at long", gate_hi[0], 0);
      oc_hi[0] = 1'b0;
      send(16'h0005);

      // R12: two sub-delay pulses do not accumulate
      oc_hi[0] = 1'b1;
      repeat (LONG - 1) @(posedge clk);
      @(negedge clk);
      oc_hi[0] = 1'b0;
      @(negedge clk);
      oc_hi[0] = 1'b1;
      repeat (LONG - 1) @(posedge clk);
      @(negedge clk);
      chk("R12 no latch on short pulses", {gate_hi[0], st_ocur}, 2'b10);
      oc_hi[0] = 1'b0;

      // R7 and R8 with lockout disabled
      ov_flag = 1'b1;
      @(negedge clk);
      chk("R7 supply flag set", st_supply, 1);
      chk("R8 no lockout when disabled", gate_hi[0], 1);
      ov_flag = 1'b0;
      send(16'h0004);
      chk("R7 flag sticky", st_supply, 1);
      send(16'h0005);
      chk("R7 cleared by reset", st_supply, 0);

      // R8 lockout enabled
      send(16'h8005);
      ov_flag = 1'b1;
      @(negedge clk);
      chk("R8 all off in lockout", {gate_hi, gate_lo}, 0);
      ov_flag = 1'b0;
      @(negedge clk);
      chk("R8 state returns", gate_hi, 3'b001);
      send(16'h0005);

      // R9 undervoltage
      uv_flag = 1'b1;
      @(negedge clk);
      chk("R9 all off", {gate_hi, gate_lo}, 0);
      uv_flag = 1'b0;
      @(negedge clk);
      chk("R9 state returns", gate_hi, 3'b001);

      // R10 thermal warning
      tw_flag[1] = 1'b1;
      @(negedge clk);
      tw_flag[1] = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 warning sticky, gate on", {st_twarn, gate_hi[0]}, 2'b11);
      send(16'h0005);
      chk("R10 cleared by reset", st_twarn, 0);

      // R11 thermal shutdown
      tsd_flag[2] = 1'b1;
      @(negedge clk);
      chk("R11 off in shutdown", {gate_hi, gate_lo}, 0);
      send(16'h0005);
      tsd_flag[2] = 1'b0;
      @(negedge clk);
      chk("R11 reset during shutdown ignored", gate_hi, 0);
      send(16'h0005);
      chk("R11 restart after cooling", gate_hi, 3'b001);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule